// File: doc/BRIEF.md
# SPI Hold Pause Gate

This block sits between the pads of a serial peripheral port and the shift logic of a slave device. It lets the bus master suspend a transfer partway through, for example while the master uses the shared clock line for another device. The transfer then picks up at the same bit once the pause ends. The pad inputs are chip select (active low), serial clock, serial data in and an active-low pause pin. All of them are resampled by the system clock through a synchroniser chain. Serial clock edges are found from the resampled levels.

From these levels the block produces one-cycle rising-edge and falling-edge enables for the downstream shift register, together with a serial data bit that holds still while paused. It also produces an enable for the data-out driver, a paused flag and a one-cycle sequence-clear pulse on every deselect. A pause, and the end of a pause, only take effect while the resampled serial clock is low. A pause requested with the clock high therefore waits for the next falling edge and consumes that edge. Pulling the pause pin low removes the output-driver enable immediately, whatever the clock is doing.

Top module: `spi_hold_gate`

## Requirements
- R1: While reset is asserted and in the first cycles after it, paused_o, sdo_en_o, shift_rise_o, shift_fall_o and seq_clear_o are all 0, whatever the pad inputs do.
- R2: While selected (synchronised cs_n_i = 0) and not paused, each rising edge of the synchronised serial clock gives exactly one cycle of shift_rise_o, and each falling edge gives exactly one cycle of shift_fall_o, two system clocks after the pad change.
- R3: With the device selected and the synchronised clock low, a low pause pin sets paused_o on the next system clock. A falling clock edge seen in that same cycle produces no shift_fall_o.
- R4: A pause requested while the synchronised clock is high does not pause the transfer. It takes effect at the next falling edge, and that edge produces no shift_fall_o. If the pause pin returns high before that edge, no pause occurs.
- R5: While paused, no shift_rise_o or shift_fall_o is produced, and sdi_o keeps the value it had before the pause, whatever sdi_i does.
- R6: A pause ends only when the pause pin is high while the synchronised clock is low. A clock edge seen in the ending cycle is not passed on, so the next edge after the pause is the first one counted.
- R7: sdo_en_o is 1 only when the device is selected, the synchronised pause pin is high, the block is not paused and sdo_drive_i is 1.
- R8: Each deselect (cs_n_i going high) produces one cycle of seq_clear_o and clears paused_o on the next system clock, including when the deselect happens during a pause.
- R9: While deselected, serial clock activity produces no shift_rise_o or shift_fall_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Pad chip select, active low |
| sck_i | input | 1 | Pad serial clock |
| sdi_i | input | 1 | Pad serial data in |
| hold_n_i | input | 1 | Pad pause request, active low |
| sdo_drive_i | input | 1 | Slave shift logic requests to drive the data-out pad |
| shift_rise_o | output | 1 | One-cycle enable for a counted rising serial clock edge |
| shift_fall_o | output | 1 | One-cycle enable for a counted falling serial clock edge |
| sdi_o | output | 1 | Serial data for the shift logic, frozen while paused |
| sdo_en_o | output | 1 | Data-out driver enable (0 means high impedance) |
| paused_o | output | 1 | Transfer is currently paused |
| seq_clear_o | output | 1 | One-cycle pulse on deselect, resets the downstream sequence |

## Verification
Two things can land in the same system cycle. A falling serial clock edge can arrive together with the start of a pause, and a deselect can arrive while a pause is in force. The bench provokes the first case by changing the pause pin and the serial clock in the same vector, so that both reach the synchroniser output on the same edge. It judges the result by counting falling-edge enables, which must be zero, and by checking that the paused flag is set and the data bit is frozen. For the second case, chip select rises while paused. The bench then expects one sequence-clear pulse, a cleared paused flag, and a clean restart when the device is selected again.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // bit positions of the pad pins inside the synchroniser vector
  localparam int PIN_W    = 4;
  localparam int PIN_CS   = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_HOLD = 3;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;

  // edge events from the previous and current sampled clock level
  function automatic sck_edge_t edge_of(input logic prev_lvl, input logic cur_lvl);
    sck_edge_t e;
    e.rise = cur_lvl & ~prev_lvl;
    e.fall = ~cur_lvl & prev_lvl;
    return e;
  endfunction

  // a pause may begin only with the clock low
  function automatic logic may_enter(input logic paused, input logic sel,
                                     input logic hold_lvl, input logic sck_lvl);
    return sel & ~paused & ~hold_lvl & ~sck_lvl;
  endfunction

  // a pause ends on deselect, or on a released pin with the clock low
  function automatic logic may_leave(input logic paused, input logic sel,
                                     input logic hold_lvl, input logic sck_lvl);
    return paused & (~sel | (hold_lvl & ~sck_lvl));
  endfunction

  function automatic logic next_paused(input logic paused, input logic sel,
                                       input logic hold_lvl, input logic sck_lvl);
    if (may_enter(paused, sel, hold_lvl, sck_lvl)) return 1'b1;
    if (may_leave(paused, sel, hold_lvl, sck_lvl)) return 1'b0;
    return paused;
  endfunction

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sck_edge.sv
module sck_edge
  import spi_hold_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic      prev_q;
  sck_edge_t ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= sck_lvl_i;
  end

  assign ev     = edge_of(prev_q, sck_lvl_i);
  assign rise_o = ev.rise;
  assign fall_o = ev.fall;

endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic hold_lvl_i,
  input  logic sck_lvl_i,
  input  logic sdi_lvl_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic drive_i,
  output logic rise_en_o,
  output logic fall_en_o,
  output logic sdi_o,
  output logic sdo_en_o,
  output logic paused_o,
  output logic seq_clear_o,
  output logic enter_o,
  output logic leave_o,
  output logic gate_o
);

  logic paused_q;
  logic sel_q;
  logic sdi_q;

  // named events for the checker
  assign enter_o = may_enter(paused_q, sel_i, hold_lvl_i, sck_lvl_i);
  assign leave_o = may_leave(paused_q, sel_i, hold_lvl_i, sck_lvl_i);
  // edges are swallowed while paused and in the cycle a pause begins
  assign gate_o  = paused_q | enter_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused_q <= 1'b0;
      sel_q    <= 1'b0;
      sdi_q    <= 1'b0;
    end else begin
      paused_q <= next_paused(paused_q, sel_i, hold_lvl_i, sck_lvl_i);
      sel_q    <= sel_i;
      if (!gate_o) sdi_q <= sdi_lvl_i;
    end
  end

  assign rise_en_o   = rise_i & sel_i & ~gate_o;
  assign fall_en_o   = fall_i & sel_i & ~gate_o;
  assign sdi_o       = gate_o ? sdi_q : sdi_lvl_i;
  assign sdo_en_o    = sel_i & hold_lvl_i & ~paused_q & drive_i;
  assign paused_o    = paused_q;
  assign seq_clear_o = sel_q & ~sel_i;

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic SCK_IDLE    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic hold_n_i,
  input  logic sdo_drive_i,
  output logic shift_rise_o,
  output logic shift_fall_o,
  output logic sdi_o,
  output logic sdo_en_o,
  output logic paused_o,
  output logic seq_clear_o
);

  localparam logic [PIN_W-1:0] PIN_RST = (PIN_W'(1) << PIN_CS)
                                       | (PIN_W'(SCK_IDLE) << PIN_SCK)
                                       | (PIN_W'(1) << PIN_HOLD);

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  logic sel;
  logic sck_lvl;
  logic sdi_lvl;
  logic hold_lvl;
  logic sck_rise;
  logic sck_fall;
  logic enter_w;
  logic leave_w;
  logic gate_w;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n_i;
    pins_raw[PIN_SCK]  = sck_i;
    pins_raw[PIN_SDI]  = sdi_i;
    pins_raw[PIN_HOLD] = hold_n_i;
  end

  hold_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign sel      = ~pins_s[PIN_CS];
  assign sck_lvl  = pins_s[PIN_SCK];
  assign sdi_lvl  = pins_s[PIN_SDI];
  assign hold_lvl = pins_s[PIN_HOLD];

  sck_edge #(.IDLE_LVL(SCK_IDLE)) edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_lvl_i (sck_lvl),
    .rise_o    (sck_rise),
    .fall_o    (sck_fall)
  );

  hold_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel),
    .hold_lvl_i  (hold_lvl),
    .sck_lvl_i   (sck_lvl),
    .sdi_lvl_i   (sdi_lvl),
    .rise_i      (sck_rise),
    .fall_i      (sck_fall),
    .drive_i     (sdo_drive_i),
    .rise_en_o   (shift_rise_o),
    .fall_en_o   (shift_fall_o),
    .sdi_o       (sdi_o),
    .sdo_en_o    (sdo_en_o),
    .paused_o    (paused_o),
    .seq_clear_o (seq_clear_o),
    .enter_o     (enter_w),
    .leave_o     (leave_w),
    .gate_o      (gate_w)
  );

endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic hold_lvl,
  input logic sck_lvl,
  input logic enter_w,
  input logic leave_w,
  input logic shift_rise_o,
  input logic shift_fall_o,
  input logic sdi_o,
  input logic sdo_en_o,
  input logic paused_o,
  input logic seq_clear_o
);

  // R2
  rise_only_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise_o |-> (sel && !paused_o && !shift_fall_o));

  // R3
  entry_low_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused_o) |-> $past(sel && !hold_lvl && !sck_lvl));

  // R4
  fall_swallowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_w |-> !shift_fall_o);

  // R5
  frozen_sdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_o && $past(paused_o)) |-> $stable(sdi_o));

  // R6
  resume_low_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused_o) |-> $past(!sel || (hold_lvl && !sck_lvl)));

  // R6
  leave_swallows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave_w |-> !(shift_rise_o || shift_fall_o));

  // R7
  so_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_o || !hold_lvl) |-> !sdo_en_o);

  // R8
  clear_unpauses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clear_o |=> !paused_o);

endmodule

bind spi_hold_gate spi_hold_gate_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel          (sel),
  .hold_lvl     (hold_lvl),
  .sck_lvl      (sck_lvl),
  .enter_w      (enter_w),
  .leave_w      (leave_w),
  .shift_rise_o (shift_rise_o),
  .shift_fall_o (shift_fall_o),
  .sdi_o        (sdi_o),
  .sdo_en_o     (sdo_en_o),
  .paused_o     (paused_o),
  .seq_clear_o  (seq_clear_o)
);

// File: tb/spi_hold_gate_tb_top.sv
`timescale 1ns/1ps
module spi_hold_gate_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1, drv = 1'b0;
  logic rise_o, fall_o, sdi_q, oe_o, paused_o, clr_o;

  always #2.5 clk = ~clk;  // 200 MHz

  spi_hold_gate dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n),
    .sck_i        (sck),
    .sdi_i        (sdi),
    .hold_n_i     (hold_n),
    .sdo_drive_i  (drv),
    .shift_rise_o (rise_o),
    .shift_fall_o (fall_o),
    .sdi_o        (sdi_q),
    .sdo_en_o     (oe_o),
    .paused_o     (paused_o),
    .seq_clear_o  (clr_o)
  );

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // {cs_n, sck, sdi, hold_n, drv, exp_paused, exp_oe, exp_rise, exp_fall, exp_sdi, exp_clr}
  localparam int NV = 24;
  localparam logic [10:0] VEC [NV] = '{
    11'b10010_000000,  // idle, deselected
    11'b11010_000000,  // R9 clock rises while deselected
    11'b10010_000000,  // R9 clock falls while deselected
    11'b00111_010010,  // select, data 1
    11'b01111_011010,  // R2 rising edge counted
    11'b00011_010100,  // R2 falling edge counted
    11'b01011_011000,  // R2 rising edge
    11'b01001_000000,  // R4 request with clock high: deferred, driver off (R7)
    11'b00101_100000,  // R4 falling edge consumed, pause begins, data frozen
    11'b01001_100000,  // R5 rising edge blocked
    11'b01111_100000,  // R6 pin high with clock high: still paused
    11'b00111_010010,  // R6 clock low: resume, edge in that cycle swallowed
    11'b01111_011010,  // R6 first counted edge after pause
    11'b01101_000010,  // R4 request with clock high again
    11'b01111_010010,  // R4 released before the fall: no pause
    11'b00101_100010,  // R3 pause and falling edge together
    11'b01001_100010,  // R5 data change and edge ignored
    11'b00001_100010,  // R5 falling edge ignored
    11'b00011_010000,  // R6 resume with clock low
    11'b00001_100000,  // R3 immediate pause, clock low
    11'b10001_000001,  // R8 deselect during pause
    11'b00011_010000,  // re-select: clean start
    11'b00010_000000,  // R7 drive request removed
    11'b10010_000001   // R8 deselect
  };

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin : main
    int rise_n, fall_n, clr_n;
    // R1: activity during reset gives nothing
    cs_n = 1'b0; hold_n = 1'b1; drv = 1'b1;
    rise_n = 0; fall_n = 0; clr_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sck = ~sck;
      rise_n += int'(rise_o); fall_n += int'(fall_o); clr_n += int'(clr_o);
      check("R1 oe in reset", int'(oe_o), 0);
      check("R1 paused in reset", int'(paused_o), 0);
    end
    check("R1 edges in reset", rise_n + fall_n + clr_n, 0);
    cs_n = 1'b1; sck = 1'b0; drv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe after reset", int'(oe_o), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {cs_n, sck, sdi, hold_n, drv} = VEC[v][10:6];
      rise_n = 0; fall_n = 0; clr_n = 0;
      for (int c = 0; c < 5; c++) begin
        @(posedge clk);
        @(negedge clk);
        rise_n += int'(rise_o); fall_n += int'(fall_o); clr_n += int'(clr_o);
      end
      check($sformatf("R3/R4/R6/R8 paused v%0d", v), int'(paused_o), int'(VEC[v][5]));
      check($sformatf("R7 oe v%0d", v), int'(oe_o), int'(VEC[v][4]));
      check($sformatf("R2/R5/R9 rise v%0d", v), rise_n, int'(VEC[v][3]));
      check($sformatf("R2/R4/R5 fall v%0d", v), fall_n, int'(VEC[v][2]));
      check($sformatf("R5 sdi v%0d", v), int'(sdi_q), int'(VEC[v][1]));
      check($sformatf("R8 clear v%0d", v), clr_n, int'(VEC[v][0]));
    end

    // R1: reset in the middle of a pause
    @(negedge clk);
    cs_n = 1'b0; hold_n = 1'b1; drv = 1'b1; sck = 1'b0;
    repeat (4) @(negedge clk);
    hold_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 paused before reset", int'(paused_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 paused cleared by reset", int'(paused_o), 0);
    check("R1 oe cleared by reset", int'(oe_o), 0);
    rst_n = 1'b1;
    hold_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 oe after reset and reselect", int'(oe_o), 1);

    // R2: latency of a rising edge is two system clocks
    @(negedge clk);
    sck = 1'b1;
    @(negedge clk);
    check("R2 no rise after one clock", int'(rise_o), 0);
    @(negedge clk);
    check("R2 rise after two clocks", int'(rise_o), 1);
    @(negedge clk);
    check("R2 rise lasts one cycle", int'(rise_o), 0);

    done = 1'b1;
    finish_run();
  end

endmodule